// File: doc/BRIEF.md
# Word-Clock Framing Checker

This block sits in the bit-clock domain of an audio serial port. It watches the word-clock line on every bit-clock rising edge. It follows the frame structure it expects, then checks each word-clock transition against that structure. Every phase starts on a word-clock edge. A phase then runs through a data delay period of a configured length, a configured number of word slots of a configured length, and an idle period that lasts until the next edge. The block works in two modes. In dual-phase mode, both transitions of the word clock start a phase. In single-phase mode, only a rising transition starts a frame that holds all channels.

When the block sees a mode-specific framing violation, it raises a one-cycle error pulse. It then enters a lost state and stays there until a restart. A restart sends it back to waiting for the first valid edge and samples the configuration inputs. The configuration inputs are also sampled on the first clock after reset. Some word-clock edges arrive during the word slots or the idle period without breaking a rule. The block tolerates these edges on purpose, and they do not re-align the phase.

States:
- `ST_SYNC_WAIT` waits for an edge.
- `ST_DELAY` counts the data delay.
- `ST_WORD` counts the bits and the slot index.
- `ST_IDLE` waits for the next phase.
- `ST_LOST` holds after an error.

Transitions:
- SYNC_WAIT→DELAY, or SYNC_WAIT→WORD when the delay is zero, on an edge.
- DELAY→WORD when the delay count is reached.
- DELAY→LOST on any edge.
- WORD→IDLE after the last bit of the last slot.
- WORD→LOST on a rule-breaking edge.
- IDLE→DELAY or IDLE→WORD on a valid edge.
- IDLE→LOST on a too-early edge in dual-phase mode.
- Any state→SYNC_WAIT on restart.

Top module: `wclk_frame_checker`

## Requirements
- R1: After reset, `frame_err` and `locked` are 0, and they stay 0 while the word clock does not change.
- R2: In the wait state, the first word-clock edge starts a phase. `locked` reads 1 after that bit-clock edge and no error is raised. In single-phase mode, only a rising word-clock transition counts as an edge. In dual-phase mode, both transitions count.
- R3: An edge seen during the data delay cycles raises `frame_err` after that bit-clock edge and clears `locked`. The delay cycles are the `dly_len` cycles right after the edge that started the phase.
- R4: In dual-phase mode, an edge during the word slots that is 4 or more cycles after the previous edge raises no error. It keeps `locked` at 1 and does not restart the phase.
- R5: In dual-phase mode, an edge fewer than 4 bit-clock cycles after the previous word-clock edge is an error. This holds outside the wait and lost states.
- R6: In single-phase mode, a rising edge during a slot other than the last one is an error. A rising edge during the last slot is ignored. A falling edge is never an error.
- R7: `frame_err` is high for exactly one cycle. While lost, `locked` is 0 and no further edge raises `frame_err`.
- R8: A high `restart` at a bit-clock edge returns the block to the wait state with both outputs 0. The mode, `dly_len`, `word_len` and `chan_cnt` are captured at that edge only. Later changes to these inputs have no effect until the next restart.
- R9: A phase starting with an edge at cycle t takes 1 + delay + word length × channel count cycles. After that it is in idle, and an edge seen in idle starts a new phase with no error.
- R10: A `word_len` or `chan_cnt` of zero is taken as one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous restart to the wait state; captures configuration |
| wclk | input | 1 | Word clock, sampled on each bit-clock edge |
| mode_single | input | 1 | 1 = single-phase multichannel, 0 = dual-phase |
| dly_len | input | DLY_W | Data delay length in bit clocks |
| word_len | input | WLEN_W | Bits per word slot |
| chan_cnt | input | CH_W | Word slots per phase |
| frame_err | output | 1 | One-cycle registered framing error pulse |
| locked | output | 1 | 1 while following a frame (delay, word or idle state) |

## Verification
The checker watches several rules on every cycle:
- an edge in the delay state and a too-close edge in dual-phase mode both produce the pulse;
- the pulse lasts one cycle and always comes with loss of lock;
- the lost state stays silent;
- a restart clears both outputs;
- lock can only rise after an edge.

Some behaviour depends on slot position and cycle counts, which the bench's scripted frames show. This covers:
- single-phase slot-position errors;
- tolerance of late edges in the last slot;
- where the idle period begins;
- configuration captured only at restart;
- clamping of zero lengths.

// File: rtl/wcf_pkg.sv
package wcf_pkg;

    typedef enum logic [2:0] {
        ST_SYNC_WAIT = 3'd0,
        ST_DELAY     = 3'd1,
        ST_WORD      = 3'd2,
        ST_IDLE      = 3'd3,
        ST_LOST      = 3'd4
    } wcf_state_e;

    // Minimum spacing, in bit clocks, between two dual-phase word-clock edges
    localparam int unsigned WCF_MIN_GAP = 4;

endpackage

// File: rtl/wcf_cfg_latch.sv
module wcf_cfg_latch #(
    parameter int unsigned DLY_W  = 2,
    parameter int unsigned WLEN_W = 6,
    parameter int unsigned CH_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              single_i,
    input  logic [DLY_W-1:0]  dly_i,
    input  logic [WLEN_W-1:0] word_i,
    input  logic [CH_W-1:0]   chan_i,
    output logic              single_o,
    output logic [DLY_W-1:0]  dly_o,
    output logic [WLEN_W-1:0] word_o,
    output logic [CH_W-1:0]   chan_o
);

    localparam logic [WLEN_W-1:0] WORD_ONE = WLEN_W'(1);
    localparam logic [CH_W-1:0]   CHAN_ONE = CH_W'(1);

    logic armed_q;

    // Capture on the first clock after reset and on every restart
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q  <= 1'b0;
            single_o <= 1'b0;
            dly_o    <= '0;
            word_o   <= WORD_ONE;
            chan_o   <= CHAN_ONE;
        end else if (restart || !armed_q) begin
            armed_q  <= 1'b1;
            single_o <= single_i;
            dly_o    <= dly_i;
            word_o   <= (word_i == '0) ? WORD_ONE : word_i;
            chan_o   <= (chan_i == '0) ? CHAN_ONE : chan_i;
        end
    end

endmodule

// File: rtl/wcf_edge_det.sv
module wcf_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic wclk,
    input  logic single_mode,
    output logic edge_hit
);

    logic wclk_q;
    logic rise_c;
    logic fall_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wclk_q <= 1'b0;
        end else begin
            wclk_q <= wclk;
        end
    end

    always_comb begin
        rise_c   = wclk & ~wclk_q;
        fall_c   = ~wclk & wclk_q;
        edge_hit = single_mode ? rise_c : (rise_c | fall_c);
    end

endmodule

// File: rtl/wcf_gap_timer.sv
module wcf_gap_timer #(
    parameter int unsigned MIN_GAP = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic edge_hit,
    output logic short_gap
);

    localparam int unsigned CW = $clog2(MIN_GAP + 1);
    localparam logic [CW-1:0] GAP_SAT = CW'(MIN_GAP);

    logic [CW-1:0] gap_q;

    // Cycles since the last word-clock edge, saturating at MIN_GAP
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= GAP_SAT;
        end else if (restart) begin
            gap_q <= GAP_SAT;
        end else if (edge_hit) begin
            gap_q <= CW'(1);
        end else if (gap_q < GAP_SAT) begin
            gap_q <= gap_q + CW'(1);
        end
    end

    assign short_gap = (gap_q < GAP_SAT);

endmodule

// File: rtl/wcf_phase_fsm.sv
module wcf_phase_fsm
    import wcf_pkg::*;
#(
    parameter int unsigned DLY_W  = 2,
    parameter int unsigned WLEN_W = 6,
    parameter int unsigned CH_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              edge_hit,
    input  logic              short_gap,
    input  logic              cfg_single,
    input  logic [DLY_W-1:0]  cfg_dly,
    input  logic [WLEN_W-1:0] cfg_word,
    input  logic [CH_W-1:0]   cfg_chan,
    output wcf_state_e        state,
    output logic              frame_err,
    output logic              locked
);

    wcf_state_e        state_q, nxt_state;
    logic [DLY_W-1:0]  dly_cnt_q, nxt_dly_cnt;
    logic [WLEN_W-1:0] bit_cnt_q, nxt_bit_cnt;
    logic [CH_W-1:0]   slot_q, nxt_slot;
    logic              viol_c;
    logic [DLY_W-1:0]  dly_last;
    logic [WLEN_W-1:0] bit_last;
    logic [CH_W-1:0]   slot_last;
    logic              slot_end;
    logic              frame_end;
    wcf_state_e        start_state;

    always_comb begin
        dly_last    = cfg_dly - DLY_W'(1);
        bit_last    = cfg_word - WLEN_W'(1);
        slot_last   = cfg_chan - CH_W'(1);
        slot_end    = (bit_cnt_q == bit_last);
        frame_end   = slot_end && (slot_q == slot_last);
        start_state = (cfg_dly == '0) ? ST_WORD : ST_DELAY;
    end

    // Next-state and violation logic
    always_comb begin
        nxt_state   = state_q;
        nxt_dly_cnt = dly_cnt_q;
        nxt_bit_cnt = bit_cnt_q;
        nxt_slot    = slot_q;
        viol_c      = 1'b0;
        unique case (state_q)
            ST_SYNC_WAIT: begin
                if (edge_hit) begin
                    nxt_state   = start_state;
                    nxt_dly_cnt = '0;
                    nxt_bit_cnt = '0;
                    nxt_slot    = '0;
                end
            end
            ST_DELAY: begin
                if (edge_hit) begin
                    viol_c = 1'b1;
                end else if (dly_cnt_q == dly_last) begin
                    nxt_state   = ST_WORD;
                    nxt_bit_cnt = '0;
                    nxt_slot    = '0;
                end else begin
                    nxt_dly_cnt = dly_cnt_q + DLY_W'(1);
                end
            end
            ST_WORD: begin
                if (edge_hit && (cfg_single ? (slot_q != slot_last) : short_gap)) begin
                    viol_c = 1'b1;
                end else if (frame_end) begin
                    nxt_state   = ST_IDLE;
                    nxt_bit_cnt = '0;
                    nxt_slot    = '0;
                end else if (slot_end) begin
                    nxt_bit_cnt = '0;
                    nxt_slot    = slot_q + CH_W'(1);
                end else begin
                    nxt_bit_cnt = bit_cnt_q + WLEN_W'(1);
                end
            end
            ST_IDLE: begin
                if (edge_hit) begin
                    if (!cfg_single && short_gap) begin
                        viol_c = 1'b1;
                    end else begin
                        nxt_state   = start_state;
                        nxt_dly_cnt = '0;
                        nxt_bit_cnt = '0;
                        nxt_slot    = '0;
                    end
                end
            end
            ST_LOST: begin
                nxt_state = ST_LOST;
            end
            default: begin
                nxt_state = ST_LOST;
            end
        endcase
        if (viol_c) begin
            nxt_state = ST_LOST;
        end
        if (restart) begin
            nxt_state   = ST_SYNC_WAIT;
            nxt_dly_cnt = '0;
            nxt_bit_cnt = '0;
            nxt_slot    = '0;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_SYNC_WAIT;
            dly_cnt_q <= '0;
            bit_cnt_q <= '0;
            slot_q    <= '0;
        end else begin
            state_q   <= nxt_state;
            dly_cnt_q <= nxt_dly_cnt;
            bit_cnt_q <= nxt_bit_cnt;
            slot_q    <= nxt_slot;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_err <= 1'b0;
            locked    <= 1'b0;
        end else begin
            frame_err <= viol_c && !restart;
            locked    <= (nxt_state == ST_DELAY) || (nxt_state == ST_WORD)
                      || (nxt_state == ST_IDLE);
        end
    end

    assign state = state_q;

endmodule

// File: rtl/wclk_frame_checker.sv
module wclk_frame_checker
    import wcf_pkg::*;
#(
    parameter int unsigned DLY_W  = 2,
    parameter int unsigned WLEN_W = 6,
    parameter int unsigned CH_W   = 4
) (
    input  logic              bclk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              wclk,
    input  logic              mode_single,
    input  logic [DLY_W-1:0]  dly_len,
    input  logic [WLEN_W-1:0] word_len,
    input  logic [CH_W-1:0]   chan_cnt,
    output logic              frame_err,
    output logic              locked
);

    logic              cfg_single;
    logic [DLY_W-1:0]  cfg_dly;
    logic [WLEN_W-1:0] cfg_word;
    logic [CH_W-1:0]   cfg_chan;
    logic              edge_hit;
    logic              short_gap;
    wcf_state_e        fsm_state;

    wcf_cfg_latch #(
        .DLY_W (DLY_W),
        .WLEN_W(WLEN_W),
        .CH_W  (CH_W)
    ) u_cfg (
        .clk     (bclk),
        .rst_n   (rst_n),
        .restart (restart),
        .single_i(mode_single),
        .dly_i   (dly_len),
        .word_i  (word_len),
        .chan_i  (chan_cnt),
        .single_o(cfg_single),
        .dly_o   (cfg_dly),
        .word_o  (cfg_word),
        .chan_o  (cfg_chan)
    );

    wcf_edge_det u_edge (
        .clk        (bclk),
        .rst_n      (rst_n),
        .wclk       (wclk),
        .single_mode(cfg_single),
        .edge_hit   (edge_hit)
    );

    wcf_gap_timer #(
        .MIN_GAP(WCF_MIN_GAP)
    ) u_gap (
        .clk      (bclk),
        .rst_n    (rst_n),
        .restart  (restart),
        .edge_hit (edge_hit),
        .short_gap(short_gap)
    );

    wcf_phase_fsm #(
        .DLY_W (DLY_W),
        .WLEN_W(WLEN_W),
        .CH_W  (CH_W)
    ) u_fsm (
        .clk       (bclk),
        .rst_n     (rst_n),
        .restart   (restart),
        .edge_hit  (edge_hit),
        .short_gap (short_gap),
        .cfg_single(cfg_single),
        .cfg_dly   (cfg_dly),
        .cfg_word  (cfg_word),
        .cfg_chan  (cfg_chan),
        .state     (fsm_state),
        .frame_err (frame_err),
        .locked    (locked)
    );

endmodule

// File: rtl/wclk_frame_checker_sva.sv
module wclk_frame_checker_sva
    import wcf_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       restart,
    input logic       edge_hit,
    input logic       short_gap,
    input logic       cfg_single,
    input wcf_state_e state,
    input logic       frame_err,
    input logic       locked
);

    assert_lock_needs_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(edge_hit));

    assert_delay_edge_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DELAY && edge_hit && !restart) |=> frame_err);

    assert_late_word_edge_ok_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_single && state == ST_WORD && edge_hit && !short_gap && !restart)
        |=> (locked && !frame_err));

    assert_short_gap_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_single && short_gap && edge_hit && !restart
         && (state == ST_WORD || state == ST_IDLE)) |=> frame_err);

    assert_err_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> !frame_err);

    assert_err_drops_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> !locked);

    assert_lost_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOST && !restart) |=> (!frame_err && !locked));

    assert_restart_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!frame_err && !locked));

endmodule

bind wclk_frame_checker wclk_frame_checker_sva u_sva (
    .clk       (bclk),
    .rst_n     (rst_n),
    .restart   (restart),
    .edge_hit  (edge_hit),
    .short_gap (short_gap),
    .cfg_single(cfg_single),
    .state     (fsm_state),
    .frame_err (frame_err),
    .locked    (locked)
);

// File: tb/wclk_frame_checker_tb_top.sv
`timescale 1ns/1ps
module wclk_frame_checker_tb_top;

    localparam int DLY_W  = 2;
    localparam int WLEN_W = 6;
    localparam int CH_W   = 4;

    logic              bclk = 1'b0;
    logic              rst_n = 1'b0;
    logic              restart = 1'b0;
    logic              wclk = 1'b0;
    logic              mode_single = 1'b0;
    logic [DLY_W-1:0]  dly_len = 2'd1;
    logic [WLEN_W-1:0] word_len = 6'd2;
    logic [CH_W-1:0]   chan_cnt = 4'd2;
    logic              frame_err;
    logic              locked;

    int    n_vec  = 0;
    int    n_fail = 0;
    bit    exp_err_q[$];
    bit    exp_lock_q[$];
    string tag_q[$];

    always #10 bclk = ~bclk;  // 50 MHz

    wclk_frame_checker #(
        .DLY_W (DLY_W),
        .WLEN_W(WLEN_W),
        .CH_W  (CH_W)
    ) dut_i (
        .bclk       (bclk),
        .rst_n      (rst_n),
        .restart    (restart),
        .wclk       (wclk),
        .mode_single(mode_single),
        .dly_len    (dly_len),
        .word_len   (word_len),
        .chan_cnt   (chan_cnt),
        .frame_err  (frame_err),
        .locked     (locked)
    );

    // Driver: one bit-clock step, expected outputs after the next rising edge
    task automatic step(input logic w, input logic rs, input bit e_err,
                        input bit e_lock, input string tag);
        @(negedge bclk);
        wclk    = w;
        restart = rs;
        exp_err_q.push_back(e_err);
        exp_lock_q.push_back(e_lock);
        tag_q.push_back(tag);
    endtask

    task automatic hold(input int n, input bit e_lock, input string tag);
        for (int i = 0; i < n; i++) begin
            step(wclk, 1'b0, 1'b0, e_lock, tag);
        end
    endtask

    // Monitor: compare a quarter period after each rising edge
    initial begin
        forever begin
            @(posedge bclk);
            #5;
            if (tag_q.size() > 0) begin
                bit    ee;
                bit    el;
                string t;
                ee = exp_err_q.pop_front();
                el = exp_lock_q.pop_front();
                t  = tag_q.pop_front();
                n_vec++;
                if (frame_err !== ee || locked !== el) begin
                    n_fail++;
                    $display("FAIL %s: err=%b lock=%b expected err=%b lock=%b",
                             t, frame_err, locked, ee, el);
                end
            end
        end
    end

    bit finished = 1'b0;

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge bclk);
        rst_n = 1'b1;

        // R1: reset state, quiet word clock
        hold(3, 1'b0, "R1");

        // Dual-phase, delay 1, 2 slots of 2 bits: phase length 6
        step(1'b1, 1'b0, 1'b0, 1'b1, "R2");      // j=0 start
        hold(5, 1'b1, "R9");                     // j=1..5
        step(1'b0, 1'b0, 1'b0, 1'b1, "R9");      // j=6 idle edge, new phase
        hold(3, 1'b1, "R9");                     // j=1..3
        step(1'b1, 1'b0, 1'b0, 1'b1, "R4");      // j=4 word slot, ignored
        hold(3, 1'b1, "R4");                     // j=5..7
        step(1'b0, 1'b0, 1'b0, 1'b1, "R9");      // j=8 idle, gap 4
        hold(1, 1'b1, "R9");
        step(1'b1, 1'b0, 1'b1, 1'b0, "R5");      // j=2 gap too short
        hold(1, 1'b0, "R7");
        step(1'b0, 1'b0, 1'b0, 1'b0, "R7");      // edges while lost
        step(1'b1, 1'b0, 1'b0, 1'b0, "R7");

        // R8: restart, then wait for an edge
        step(1'b1, 1'b1, 1'b0, 1'b0, "R8");
        hold(2, 1'b0, "R8");
        step(1'b0, 1'b0, 1'b0, 1'b1, "R2");
        step(1'b1, 1'b0, 1'b1, 1'b0, "R3");      // edge inside delay
        hold(1, 1'b0, "R7");

        // Dual-phase, delay 0: edge 3 cycles later, in word slots
        dly_len = 2'd0;
        step(1'b1, 1'b1, 1'b0, 1'b0, "R8");
        step(1'b0, 1'b0, 1'b0, 1'b1, "R2");
        hold(2, 1'b1, "R5");
        step(1'b1, 1'b0, 1'b1, 1'b0, "R5");

        // Single-phase, delay 0, 2 slots of 2 bits
        mode_single = 1'b1;
        step(1'b0, 1'b1, 1'b0, 1'b0, "R8");
        hold(1, 1'b0, "R8");
        chan_cnt = 4'd1;                         // not captured until restart
        step(1'b1, 1'b0, 1'b0, 1'b1, "R2");      // j=0
        step(1'b0, 1'b0, 1'b0, 1'b1, "R6");      // fall ignored
        hold(1, 1'b1, "R6");
        step(1'b1, 1'b0, 1'b0, 1'b1, "R6");      // j=3 last slot, ignored
        step(1'b0, 1'b0, 1'b0, 1'b1, "R6");
        step(1'b1, 1'b0, 1'b0, 1'b1, "R9");      // j=5 idle, new frame
        step(1'b0, 1'b0, 1'b0, 1'b1, "R9");
        step(1'b1, 1'b0, 1'b1, 1'b0, "R8");      // j=2 slot 0 of 2 captured
        step(1'b0, 1'b0, 1'b0, 1'b0, "R7");

        // Single-phase, delay 2: rising edge inside delay
        dly_len  = 2'd2;
        chan_cnt = 4'd2;
        step(1'b0, 1'b1, 1'b0, 1'b0, "R8");
        hold(1, 1'b0, "R8");
        step(1'b1, 1'b0, 1'b0, 1'b1, "R2");
        step(1'b0, 1'b0, 1'b0, 1'b1, "R3");
        step(1'b1, 1'b0, 1'b1, 1'b0, "R3");
        hold(1, 1'b0, "R7");

        // R10: zero word length and channel count act as one
        dly_len  = 2'd0;
        word_len = 6'd0;
        chan_cnt = 4'd0;
        step(1'b0, 1'b1, 1'b0, 1'b0, "R8");
        hold(1, 1'b0, "R10");
        step(1'b1, 1'b0, 1'b0, 1'b1, "R10");
        step(1'b0, 1'b0, 1'b0, 1'b1, "R10");
        step(1'b1, 1'b0, 1'b0, 1'b1, "R10");     // j=2 idle, new frame
        step(1'b0, 1'b0, 1'b0, 1'b1, "R10");
        step(1'b1, 1'b0, 1'b0, 1'b1, "R10");

        repeat (3) @(negedge bclk);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule